// File: doc/BRIEF.md
# E1 Reframe Supervisor

This block sits beside the receive framer of a 2048 kbit/s E1 interface and decides when the framer must drop its present alignment and hunt for a new one. It watches the framer's frame-lock and CRC multiframe-lock flags, a per-submultiframe CRC error strobe and a strobe that marks each 125 µs frame boundary. From these it raises a one-cycle reframe request to the framer.

There are three causes for a request. The first is a multiframe-lock watchdog that expires a fixed number of frames after frame lock is gained. The second is a one-second CRC error tally that goes past a limit. The third is a software control bit that is held high and then released. The first two act only while the maintenance control input is high. The third acts at all times.

All intervals are counted in frame strobes, so the block needs no timebase of its own. With the default values, 64 frames make the 8 ms watchdog window and 8000 frames make the one-second error interval. The running error tally is a port, so line-quality monitors can read it.

Top module: `e1_reframe_supervisor`

## Requirements
- R1: After reset is released, `reframe_req` is 0 and `crc_err_count` is 0.
- R2: A rising edge of `fsync_ok` arms the watchdog with a count of zero, and frame strobes in that same cycle are not counted. With `maint_en` high, if `mfsync_ok` stays low, `fsync_ok` stays high and `MF_FRAMES` frame strobes arrive after the arming cycle, `reframe_req` is 1 in the cycle after the last of those strobes. No further timeout request follows until the watchdog is armed again.
- R3: If `mfsync_ok` is high in any cycle while the watchdog is armed, the watchdog stops and gives no timeout request, however many frame strobes follow.
- R4: While `maint_en` is low, neither a watchdog expiry nor a CRC error count above the limit raises `reframe_req`.
- R5: `crc_err_count` rises by one in the cycle after each `crc_err` strobe, whatever the state of `maint_en`. It saturates at 2^`ERR_W`-1 and never wraps.
- R6: A new interval begins on every `SEC_FRAMES`-th frame strobe counted from reset. In that cycle the count is set to 0, or to 1 if `crc_err` is also high.
- R7: With `maint_en` high, the error that takes the count from `ERR_LIMIT` to `ERR_LIMIT`+1 makes `reframe_req` 1 in the next cycle. Later errors in the same interval raise no further request.
- R8: A high-to-low change of `force_bit` makes `reframe_req` 1 in the next cycle, provided at least `HOLD_FRAMES` frame strobes were seen while the bit was high.
- R9: A high-to-low change of `force_bit` after fewer than `HOLD_FRAMES` frame strobes while high raises no request. A `force_bit` that stays low raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe per received frame boundary |
| fsync_ok | input | 1 | Frame alignment achieved |
| mfsync_ok | input | 1 | CRC multiframe alignment achieved |
| crc_err | input | 1 | One-cycle strobe per submultiframe CRC mismatch |
| maint_en | input | 1 | Enables the timeout and error-count triggers |
| force_bit | input | 1 | Software force-reframe control bit |
| reframe_req | output | 1 | One-cycle request to restart the frame search |
| crc_err_count | output | ERR_W | Saturating CRC error count of the current interval |

## Verification
The bench builds the block with a 4-frame watchdog, a 20-frame interval, an error limit of 5, a 4-bit counter and a one-frame hold. With these values the timeout, the limit crossing, counter saturation at 15 and the interval clear all happen within a few dozen cycles. This puts the exact boundary cycle of each trigger in reach, and also the case where an error lands on the same strobe that opens a new interval. The small counter width lets saturation be reached before the interval clear.

// File: rtl/e1_reframe_pkg.sv
package e1_reframe_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_DONE  = 2'd2
    } wd_state_t;

    typedef struct packed {
        logic mf_timeout;
        logic err_over;
        logic forced;
    } trig_t;

    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] maxv);
        return (v >= maxv) ? maxv : v + 32'd1;
    endfunction

    function automatic logic merge_triggers(input trig_t t, input logic maint);
        return (maint & (t.mf_timeout | t.err_over)) | t.forced;
    endfunction

endpackage

// File: rtl/e1_mf_watchdog.sv
module e1_mf_watchdog
    import e1_reframe_pkg::*;
#(
    parameter int MF_FRAMES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_tick,
    input  logic fsync_ok,
    input  logic mfsync_ok,
    output logic expire
);
    localparam int CW = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(MF_FRAMES - 1);

    wd_state_t      state, state_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic           fsync_q;
    logic           rise;

    assign rise = fsync_ok & ~fsync_q;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        expire  = 1'b0;
        if (!fsync_ok) begin
            state_n = WD_IDLE;
            cnt_n   = '0;
        end else if (rise) begin
            state_n = WD_ARMED;
            cnt_n   = '0;
        end else begin
            unique case (state)
                WD_ARMED: begin
                    if (mfsync_ok) begin
                        state_n = WD_DONE;
                    end else if (frame_tick) begin
                        if (cnt == LAST) begin
                            expire  = 1'b1;
                            state_n = WD_DONE;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                WD_IDLE, WD_DONE: ;
                default: state_n = WD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WD_IDLE;
            cnt     <= '0;
            fsync_q <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            fsync_q <= fsync_ok;
        end
    end

endmodule

// File: rtl/e1_err_accum.sv
module e1_err_accum
    import e1_reframe_pkg::*;
#(
    parameter int SEC_FRAMES = 8000,
    parameter int ERR_LIMIT  = 914,
    parameter int ERR_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic             crc_err,
    output logic             over,
    output logic [ERR_W-1:0] count
);
    localparam int SW = (SEC_FRAMES > 1) ? $clog2(SEC_FRAMES) : 1;
    localparam logic [SW-1:0]    SEC_LAST = SW'(SEC_FRAMES - 1);
    localparam logic [ERR_W-1:0] ERR_MAX  = '1;
    localparam logic [ERR_W-1:0] LIMIT    = ERR_W'(ERR_LIMIT);

    logic [SW-1:0]    sec_cnt;
    logic             wrap;
    logic [ERR_W-1:0] count_n;

    assign wrap = frame_tick && (sec_cnt == SEC_LAST);
    assign over = crc_err && !wrap && (count == LIMIT) && (LIMIT != ERR_MAX);

    always_comb begin
        if (wrap) begin
            count_n = crc_err ? ERR_W'(1) : '0;
        end else if (crc_err) begin
            count_n = ERR_W'(sat_inc(32'(count), 32'(ERR_MAX)));
        end else begin
            count_n = count;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_cnt <= '0;
            count   <= '0;
        end else begin
            count <= count_n;
            if (frame_tick) begin
                sec_cnt <= wrap ? '0 : sec_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/e1_force_edge.sv
module e1_force_edge
    import e1_reframe_pkg::*;
#(
    parameter int HOLD_FRAMES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_tick,
    input  logic force_bit,
    output logic fire
);
    localparam int HW = $clog2(HOLD_FRAMES + 1);
    localparam logic [HW-1:0] HOLD = HW'(HOLD_FRAMES);

    logic [HW-1:0] hold_cnt;
    logic          force_q;
    logic          qualified;

    assign qualified = (hold_cnt >= HOLD);
    assign fire      = force_q && !force_bit && qualified;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            force_q  <= 1'b0;
        end else begin
            force_q <= force_bit;
            if (!force_bit) begin
                hold_cnt <= '0;
            end else if (frame_tick && !qualified) begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/e1_reframe_supervisor.sv
module e1_reframe_supervisor
    import e1_reframe_pkg::*;
#(
    parameter int MF_FRAMES   = 64,
    parameter int SEC_FRAMES  = 8000,
    parameter int ERR_LIMIT   = 914,
    parameter int ERR_W       = 10,
    parameter int HOLD_FRAMES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic             fsync_ok,
    input  logic             mfsync_ok,
    input  logic             crc_err,
    input  logic             maint_en,
    input  logic             force_bit,
    output logic             reframe_req,
    output logic [ERR_W-1:0] crc_err_count
);
    trig_t trig;

    e1_mf_watchdog #(.MF_FRAMES(MF_FRAMES)) u_wd (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .fsync_ok   (fsync_ok),
        .mfsync_ok  (mfsync_ok),
        .expire     (trig.mf_timeout)
    );

    e1_err_accum #(
        .SEC_FRAMES (SEC_FRAMES),
        .ERR_LIMIT  (ERR_LIMIT),
        .ERR_W      (ERR_W)
    ) u_err (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .crc_err    (crc_err),
        .over       (trig.err_over),
        .count      (crc_err_count)
    );

    e1_force_edge #(.HOLD_FRAMES(HOLD_FRAMES)) u_force (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .force_bit  (force_bit),
        .fire       (trig.forced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reframe_req <= 1'b0;
        end else begin
            reframe_req <= merge_triggers(trig, maint_en);
        end
    end

endmodule

// File: rtl/e1_reframe_supervisor_chk.sv
module e1_reframe_supervisor_chk #(
    parameter int ERR_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_tick,
    input logic             crc_err,
    input logic             maint_en,
    input logic             force_bit,
    input logic             reframe_req,
    input logic [ERR_W-1:0] crc_err_count
);
    localparam logic [ERR_W-1:0] CMAX = '1;

    logic force_prev;
    always_ff @(posedge clk) begin
        if (rst) force_prev <= 1'b0;
        else     force_prev <= force_bit;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!reframe_req && crc_err_count == '0));

    a_r4_maint_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (!maint_en && !(force_prev && !force_bit)) |=> !reframe_req);

    a_r9_steady_low: assert property (@(posedge clk) disable iff (rst)
        (!maint_en && !force_prev && !force_bit) |=> !reframe_req);

    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (!frame_tick && crc_err && crc_err_count != CMAX)
            |=> crc_err_count == $past(crc_err_count) + 1'b1);

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!frame_tick && crc_err_count == CMAX) |=> crc_err_count == CMAX);

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!frame_tick && !crc_err) |=> $stable(crc_err_count));

endmodule

bind e1_reframe_supervisor e1_reframe_supervisor_chk #(.ERR_W(ERR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_tick    (frame_tick),
    .crc_err       (crc_err),
    .maint_en      (maint_en),
    .force_bit     (force_bit),
    .reframe_req   (reframe_req),
    .crc_err_count (crc_err_count)
);

// File: tb/test_e1_reframe_supervisor.sv
module test_e1_reframe_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int MF   = 4;
    localparam int SEC  = 20;
    localparam int LIM  = 5;
    localparam int EW   = 4;
    localparam int HOLD = 1;

    // vector bits: tick fsync mfsync err maint force expected_req
    localparam int NV = 10;
    localparam logic [6:0] VEC [NV] = '{
        7'b0_0_0_0_0_1_0,
        7'b1_0_0_0_0_1_0,
        7'b0_0_0_0_0_0_1,
        7'b0_0_0_0_0_0_0,
        7'b0_0_0_0_0_0_0,
        7'b0_0_0_0_0_1_0,
        7'b0_0_0_0_0_0_0,
        7'b1_0_0_0_0_1_0,
        7'b1_0_0_0_0_1_0,
        7'b0_0_0_0_0_0_1
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_tick = 1'b0, fsync_ok = 1'b0, mfsync_ok = 1'b0;
    logic crc_err = 1'b0, maint_en = 1'b0, force_bit = 1'b0;
    logic reframe_req;
    logic [EW-1:0] crc_err_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    e1_reframe_supervisor #(
        .MF_FRAMES(MF), .SEC_FRAMES(SEC), .ERR_LIMIT(LIM),
        .ERR_W(EW), .HOLD_FRAMES(HOLD)
    ) i_e1_reframe_supervisor (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .fsync_ok(fsync_ok),
        .mfsync_ok(mfsync_ok), .crc_err(crc_err), .maint_en(maint_en),
        .force_bit(force_bit), .reframe_req(reframe_req),
        .crc_err_count(crc_err_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic t, input logic fs, input logic mf,
                       input logic e, input logic m, input logic f);
        @(negedge clk);
        frame_tick = t; fsync_ok = fs; mfsync_ok = mf;
        crc_err = e; maint_en = m; force_bit = f;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        frame_tick = 0; fsync_ok = 0; mfsync_ok = 0; crc_err = 0; maint_en = 0; force_bit = 0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R1 req after reset", int'(reframe_req), 0);
        chk("R1 count after reset", int'(crc_err_count), 0);
    endtask

    initial begin
        int nreq;
        do_reset();

        // R8 / R9: force bit vector table
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
            chk($sformatf("R8/R9 force vector %0d", i), int'(reframe_req), int'(VEC[i][0]));
        end

        // R2: watchdog timeout with maintenance on
        do_reset();
        cyc(0, 1, 0, 0, 1, 0);
        chk("R2 arm cycle", int'(reframe_req), 0);
        for (int i = 1; i < MF; i++) begin
            cyc(1, 1, 0, 0, 1, 0);
            chk("R2 before timeout", int'(reframe_req), 0);
        end
        cyc(1, 1, 0, 0, 1, 0);
        chk("R2 timeout request", int'(reframe_req), 1);
        nreq = 0;
        for (int i = 0; i < 2*MF; i++) begin
            cyc(1, 1, 0, 0, 1, 0);
            nreq += int'(reframe_req);
        end
        chk("R2 no repeat after expiry", nreq, 0);

        // R2: re-arm after frame lock loss, tick in arm cycle not counted
        cyc(0, 0, 0, 0, 1, 0);
        cyc(1, 1, 0, 0, 1, 0);
        for (int i = 1; i < MF; i++) cyc(1, 1, 0, 0, 1, 0);
        chk("R2 rearm no early fire", int'(reframe_req), 0);
        cyc(1, 1, 0, 0, 1, 0);
        chk("R2 rearm timeout", int'(reframe_req), 1);

        // R3: multiframe lock stops watchdog
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 1, 0, 0, 1, 0);
        cyc(1, 1, 0, 0, 1, 0);
        cyc(0, 1, 1, 0, 1, 0);
        nreq = 0;
        for (int i = 0; i < 2*MF; i++) begin
            cyc(1, 1, 0, 0, 1, 0);
            nreq += int'(reframe_req);
        end
        chk("R3 mfsync stops watchdog", nreq, 0);

        // R4: maintenance off blocks timeout
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        nreq = 0;
        for (int i = 0; i < 2*MF; i++) begin
            cyc(1, 1, 0, 0, 0, 0);
            nreq += int'(reframe_req);
        end
        chk("R4 timeout blocked when maint off", nreq, 0);

        // R7 / R5 / R6: error accumulation
        do_reset();
        for (int i = 0; i < LIM; i++) begin
            cyc(0, 0, 0, 1, 1, 0);
            chk("R7 below limit", int'(reframe_req), 0);
        end
        chk("R5 count at limit", int'(crc_err_count), LIM);
        cyc(0, 0, 0, 1, 1, 0);
        chk("R7 crossing request", int'(reframe_req), 1);
        chk("R5 count past limit", int'(crc_err_count), LIM + 1);
        cyc(0, 0, 0, 1, 1, 0);
        chk("R7 single request per interval", int'(reframe_req), 0);
        for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 1, 0);
        chk("R5 saturates", int'(crc_err_count), (1 << EW) - 1);
        for (int i = 0; i < SEC - 1; i++) cyc(1, 0, 0, 0, 1, 0);
        chk("R6 not cleared early", int'(crc_err_count), (1 << EW) - 1);
        cyc(1, 0, 0, 0, 1, 0);
        chk("R6 cleared on interval start", int'(crc_err_count), 0);
        for (int i = 0; i < SEC - 1; i++) cyc(1, 0, 0, 0, 1, 0);
        cyc(1, 0, 0, 1, 1, 0);
        chk("R6 error on interval start counts", int'(crc_err_count), 1);

        // R4 / R5: maintenance off, errors still counted, no request
        do_reset();
        nreq = 0;
        for (int i = 0; i < LIM + 3; i++) begin
            cyc(0, 0, 0, 1, 0, 0);
            nreq += int'(reframe_req);
        end
        chk("R4 error trigger blocked", nreq, 0);
        chk("R5 counts with maint off", int'(crc_err_count), LIM + 3);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule